// File: doc/BRIEF.md
# Tick-Triggered Fork-Join Sequencer

This block is a controller that drives a group of parallel workers and one follow-on worker over a start/busy handshake. A one-cycle `tick` in the rest state launches every worker of the parallel group together. The controller waits for all of them to report busy, then for all of them to go quiet again. It then launches the follow-on ("tail") worker, waits for that worker's busy to rise and fall, and returns to rest. Any tick that arrives while a run is in progress is dropped.

The five states are REST, LAUNCH_PAIR, JOIN_PAIR, LAUNCH_TAIL and DRAIN_TAIL.

The transitions are:
- REST goes to LAUNCH_PAIR on tick and otherwise holds.
- LAUNCH_PAIR goes to JOIN_PAIR once every parallel busy is high at the same clock edge.
- JOIN_PAIR goes to LAUNCH_TAIL once every parallel busy is low.
- LAUNCH_TAIL goes to DRAIN_TAIL once the tail busy is high.
- DRAIN_TAIL goes to REST once the tail busy is low.

The start outputs are decoded from the state register alone. Each handshake therefore has two phases: the start is held until busy is seen, and a separate wait state follows until busy falls.

Top module: `tick_join_sequencer`

## Requirements
- R1: While `rst` is high, the state becomes REST at the next edge, and every start output is low in REST.
- R2: In REST, `tick` high at a clock edge moves to LAUNCH_PAIR, so every bit of `par_start` is 1 in the next cycle. Without a tick the block stays in REST with all starts low.
- R3: In LAUNCH_PAIR all bits of `par_start` are 1. The block stays in this state until every bit of `par_busy` is 1 at the same edge, then moves to JOIN_PAIR.
- R4: JOIN_PAIR drives no start and holds while any bit of `par_busy` is 1. When all bits are 0 it moves to LAUNCH_TAIL.
- R5: In LAUNCH_TAIL, `tail_start` is 1 and `par_start` is 0. The block holds until `tail_busy` is 1, then moves to DRAIN_TAIL.
- R6: DRAIN_TAIL drives no start and holds while `tail_busy` is 1. When `tail_busy` is 0 it returns to REST.
- R7: A `tick` in any state other than REST has no effect. A new run begins only from a tick seen in REST.
- R8: `tail_start` is never 1 in a cycle in which any bit of `par_start` is 1.
- R9: If one parallel worker raises and then drops busy before another has raised it, the block stays in LAUNCH_PAIR with `par_start` all ones until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Run request, sampled only in REST |
| par_start | output | PAR_WORKERS | Start requests to the parallel workers |
| par_busy | input | PAR_WORKERS | Busy flags from the parallel workers |
| tail_start | output | 1 | Start request to the tail worker |
| tail_busy | input | 1 | Busy flag from the tail worker |

## Verification
The assertions assume that each worker raises busy only after it has seen its start, and drops it once its work is done. They also assume that in a working run every parallel busy is high at some common edge. The bench models each worker with a programmable latency and run length. A worker that has finished waits for its start to drop before it can be launched again, so it never raises busy without a request. One deliberate scenario breaks the overlap assumption to exercise R9, and is then cleared with a reset.

// File: rtl/tick_join_pkg.sv
package tick_join_pkg;

    typedef enum logic [2:0] {
        SQ_REST        = 3'd0,
        SQ_LAUNCH_PAIR = 3'd1,
        SQ_JOIN_PAIR   = 3'd2,
        SQ_LAUNCH_TAIL = 3'd3,
        SQ_DRAIN_TAIL  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/tick_join_gather.sv
module tick_join_gather #(
    parameter int PAR_WORKERS = 2
) (
    input  logic [PAR_WORKERS-1:0] busy_vec,
    output logic                   all_busy,
    output logic                   none_busy
);
    logic [PAR_WORKERS:0] and_chain;
    logic [PAR_WORKERS:0] or_chain;

    assign and_chain[0] = 1'b1;
    assign or_chain[0]  = 1'b0;

    for (genvar g = 0; g < PAR_WORKERS; g++) begin : g_chain
        assign and_chain[g+1] = and_chain[g] & busy_vec[g];
        assign or_chain[g+1]  = or_chain[g]  | busy_vec[g];
    end

    assign all_busy  = and_chain[PAR_WORKERS];
    assign none_busy = ~or_chain[PAR_WORKERS];
endmodule

// File: rtl/tick_join_next.sv
module tick_join_next
    import tick_join_pkg::*;
(
    input  seq_state_t cur_state,
    input  logic       tick,
    input  logic       par_all_busy,
    input  logic       par_none_busy,
    input  logic       tail_busy,
    output seq_state_t nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            SQ_REST:        if (tick)          nxt_state = SQ_LAUNCH_PAIR;
            SQ_LAUNCH_PAIR: if (par_all_busy)  nxt_state = SQ_JOIN_PAIR;
            SQ_JOIN_PAIR:   if (par_none_busy) nxt_state = SQ_LAUNCH_TAIL;
            SQ_LAUNCH_TAIL: if (tail_busy)     nxt_state = SQ_DRAIN_TAIL;
            SQ_DRAIN_TAIL:  if (!tail_busy)    nxt_state = SQ_REST;
            default:                           nxt_state = SQ_REST;
        endcase
    end
endmodule

// File: rtl/tick_join_decode.sv
module tick_join_decode
    import tick_join_pkg::*;
#(
    parameter int PAR_WORKERS = 2
) (
    input  seq_state_t             cur_state,
    output logic [PAR_WORKERS-1:0] par_start,
    output logic                   tail_start
);
    logic launch_pair;

    always_comb begin
        launch_pair = 1'b0;
        tail_start  = 1'b0;
        unique case (cur_state)
            SQ_LAUNCH_PAIR: launch_pair = 1'b1;
            SQ_LAUNCH_TAIL: tail_start  = 1'b1;
            SQ_REST, SQ_JOIN_PAIR, SQ_DRAIN_TAIL: ;
            default: ;
        endcase
    end

    for (genvar g = 0; g < PAR_WORKERS; g++) begin : g_start
        assign par_start[g] = launch_pair;
    end
endmodule

// File: rtl/tick_join_sequencer.sv
module tick_join_sequencer
    import tick_join_pkg::*;
#(
    parameter int PAR_WORKERS = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    output logic [PAR_WORKERS-1:0] par_start,
    input  logic [PAR_WORKERS-1:0] par_busy,
    output logic                   tail_start,
    input  logic                   tail_busy
);
    localparam logic [PAR_WORKERS-1:0] ALL_ONES = {PAR_WORKERS{1'b1}};

    seq_state_t state;
    seq_state_t state_nxt;
    logic       par_all_busy;
    logic       par_none_busy;

    tick_join_gather #(.PAR_WORKERS(PAR_WORKERS)) u_gather (
        .busy_vec  (par_busy),
        .all_busy  (par_all_busy),
        .none_busy (par_none_busy)
    );

    tick_join_next u_next (
        .cur_state     (state),
        .tick          (tick),
        .par_all_busy  (par_all_busy),
        .par_none_busy (par_none_busy),
        .tail_busy     (tail_busy),
        .nxt_state     (state_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_REST;
        else     state <= state_nxt;
    end

    tick_join_decode #(.PAR_WORKERS(PAR_WORKERS)) u_decode (
        .cur_state  (state),
        .par_start  (par_start),
        .tail_start (tail_start)
    );

    assert_reset_rest_R1: assert property (@(posedge clk)
        rst |=> (state == SQ_REST && par_start == '0 && !tail_start));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_REST && !tick) |=> (par_start == '0 && !tail_start));

    assert_idle_go_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_REST && tick) |=> (par_start == ALL_ONES));

    assert_launch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LAUNCH_PAIR && par_busy != ALL_ONES) |=> (par_start == ALL_ONES));

    assert_join_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_JOIN_PAIR && par_busy != '0) |=> (state == SQ_JOIN_PAIR && par_start == '0));

    assert_tail_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(tail_start) |-> $past(state == SQ_JOIN_PAIR && par_busy == '0));

    assert_drain_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_DRAIN_TAIL && !tail_busy) |=> (state == SQ_REST && !tail_start));

    assert_tick_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_JOIN_PAIR && tick && par_busy != '0) |=> (par_start == '0));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(tail_start && par_start != '0));
endmodule

// File: tb/test_tick_join_sequencer.sv
module test_tick_join_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [NP-1:0] par_start;
    logic [NP-1:0] par_busy = '0;
    logic          tail_start;
    logic          tail_busy = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc_total = 0;

    // worker models: index 0..NP-1 parallel, NP = tail
    int  w_lat_cfg [NP+1];
    int  w_dur_cfg [NP+1];
    int  w_lat     [NP+1];
    int  w_run     [NP+1];
    bit  w_busy    [NP+1];
    bit  w_done    [NP+1];

    int  m_state = 0;   // 0 rest,1 launch pair,2 join,3 launch tail,4 drain
    bit  prev_tick_busy = 0;

    tick_join_sequencer #(.PAR_WORKERS(NP)) i_tick_join_sequencer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .par_start  (par_start),
        .par_busy   (par_busy),
        .tail_start (tail_start),
        .tail_busy  (tail_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d (model state %0d)", req, act, exp, m_state);
        end
    endtask

    task automatic config_workers(input int la, input int da, input int lb, input int db,
                                  input int lc, input int dc);
        w_lat_cfg[0] = la; w_dur_cfg[0] = da;
        w_lat_cfg[1] = lb; w_dur_cfg[1] = db;
        w_lat_cfg[NP] = lc; w_dur_cfg[NP] = dc;
        for (int i = 0; i <= NP; i++) begin
            w_lat[i] = w_lat_cfg[i]; w_run[i] = 0; w_busy[i] = 0; w_done[i] = 0;
        end
    endtask

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // one cycle: compare at negedge, then choose next inputs and advance model
    task automatic step(input bit tick_v, input bit rst_v);
        bit exp_par;
        bit exp_tail;
        bit s;
        bit all_b;
        bit none_b;
        string tag;
        @(negedge clk);
        exp_par  = (m_state == 1);
        exp_tail = (m_state == 3);
        tag = prev_tick_busy ? "R7" : req_of(m_state);
        check(par_start == {NP{exp_par}}, tag, int'(par_start), exp_par ? (1 << NP) - 1 : 0);
        check(tail_start == exp_tail, tag, int'(tail_start), int'(exp_tail));
        check(!(tail_start && par_start != '0), "R8", int'(tail_start), 0);
        for (int i = 0; i <= NP; i++) begin
            s = (i == NP) ? exp_tail : exp_par;
            if (w_busy[i]) begin
                w_run[i] = w_run[i] - 1;
                if (w_run[i] <= 0) begin w_busy[i] = 0; w_done[i] = 1; end
            end else if (s && !w_done[i]) begin
                if (w_lat[i] == 0) begin w_busy[i] = 1; w_run[i] = w_dur_cfg[i]; end
                else w_lat[i] = w_lat[i] - 1;
            end else if (!s) begin
                w_done[i] = 0; w_lat[i] = w_lat_cfg[i];
            end
        end
        for (int i = 0; i < NP; i++) par_busy[i] = w_busy[i];
        tail_busy = w_busy[NP];
        tick = tick_v;
        rst = rst_v;
        all_b = 1; none_b = 1;
        for (int i = 0; i < NP; i++) begin
            if (!w_busy[i]) all_b = 0;
            if (w_busy[i]) none_b = 0;
        end
        prev_tick_busy = tick_v && (m_state != 0) && !rst_v;
        if (rst_v) m_state = 0;
        else case (m_state)
            0: if (tick_v) m_state = 1;
            1: if (all_b) m_state = 2;
            2: if (none_b) m_state = 3;
            3: if (w_busy[NP]) m_state = 4;
            default: if (!w_busy[NP]) m_state = 0;
        endcase
    endtask

    task automatic run_scen(input int period, input int phase, input int ncyc);
        for (int c = 0; c < ncyc; c++)
            step((period > 0) && ((c % period) == phase), 1'b0);
    endtask

    initial begin
        config_workers(0, 3, 0, 5, 0, 4);
        // reset for a few cycles
        for (int c = 0; c < 3; c++) step(1'b1, 1'b1);
        @(negedge clk);
        check(par_start == '0 && !tail_start, "R1", int'(par_start), 0);
        m_state = 0;

        // basic runs, isolated ticks
        run_scen(40, 2, 120);
        // back-to-back: tick held high, skewed latencies
        config_workers(2, 6, 0, 2, 3, 1);
        run_scen(1, 0, 150);
        // frequent ticks, longer work
        config_workers(1, 10, 1, 10, 1, 8);
        run_scen(7, 3, 160);
        // reset in the middle of a run
        config_workers(0, 20, 0, 20, 0, 5);
        run_scen(0, 0, 2);
        step(1'b1, 1'b0);
        for (int c = 0; c < 6; c++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        run_scen(0, 0, 5);
        @(negedge clk);
        check(par_start == '0 && !tail_start, "R1", int'(par_start), 0);
        // broken overlap: A finishes before B starts -> stuck in launch
        config_workers(0, 2, 6, 3, 0, 2);
        step(1'b1, 1'b0);
        run_scen(0, 0, 40);
        @(negedge clk);
        check(par_start == {NP{1'b1}}, "R9", int'(par_start), (1 << NP) - 1);
        check(!tail_start, "R9", int'(tail_start), 0);
        step(1'b0, 1'b1);
        run_scen(0, 0, 4);
        @(negedge clk);
        check(par_start == '0 && !tail_start, "R1", int'(par_start), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule